// File: doc/BRIEF.md
# Systematic (23,16) Check-Bit Encoder and Syndrome Generator

The block protects 16-bit data words with a linear block code of seven check bits. In the transmit direction it builds a 23-bit systematic codeword from a data word: the data bits pass through unchanged and are placed above seven check bits. Each check bit is the XOR of a fixed, irregular subset of the data bits. The code is not a Hamming code with checks at power-of-two positions. All seven checks sit at the low end of the word, ahead of the data.

In the receive direction the block takes a 23-bit received word and recomputes the seven checks over its data field. Each recomputed check is XORed with the matching received check bit to form a 7-bit syndrome. A nonzero syndrome raises an error flag. Locating and correcting errors is left to logic downstream, which decodes the syndrome.

One valid strobe qualifies both directions together. Two parameters add an optional input register stage and an optional output register stage. With the defaults (no input stage, one output stage), results appear one cycle after they are sampled.

Top module: `cw23_codec`

## Requirements
- R1: Codeword layout is fixed. `out_code[6:0]` holds the checks, with bit 0 = C1 up to bit 6 = C7. `out_code[22:7]` holds the data unchanged, with bit 7 = D1 = `in_data[0]` up to bit 22 = D16 = `in_data[15]`. The same layout applies to `in_rword`.
- R2: The check bits follow these equations, with Dk = `in_data[k-1]`:
  - C1 = D1^D4^D6^D8^D9^D10^D14
  - C2 = D2^D4^D5^D7^D8^D11^D15
  - C3 = D3^D7^D10^D11^D13^D16
  - C4 = D1^D4^D8^D10^D12^D13
  - C5 = D2^D5^D6^D7^D8^D13^D14
  - C6 = D2^D6^D7^D11^D13^D16
  - C7 = D3^D6^D9^D11^D12^D13^D15^D16
- R3: Syndrome bit i (`out_syn[i-1]`) is received check Ci (`in_rword[i-1]`) XORed with the R2 equation for Ci, evaluated over the received data field `in_rword[22:7]`.
- R4: `out_err` is 1 exactly when `out_syn` is nonzero.
- R5: Data word 16'hF33B gives check bits 7'h54. In D1-first order that is data 1101110011001111 and checks 0010101.
- R6: With default parameters, `out_valid` and the results for an input sampled with `in_valid` high appear one clock after the sampling edge. `out_valid` is low one clock after an edge that samples `in_valid` low.
- R7: While `rst_n` is low at a clock edge (synchronous reset), the outputs after that edge are all zero: `out_valid`, `out_code`, `out_syn` and `out_err`.
- R8: An edge with `in_valid` low leaves `out_code`, `out_syn` and `out_err` unchanged, whatever the data inputs carry.
- R9: A received word that differs from a valid codeword in a single bit gives the following syndrome:
  - a flip of check bit Ci gives only syndrome bit i set;
  - a flip of data bit Dk gives the set of checks whose R2 equation contains Dk.
- R10: A codeword produced by the block and fed back as the received word gives a zero syndrome and `out_err` = 0, for all 65536 data values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_data` and `in_rword` this cycle |
| in_data | input | 16 | Data word to encode, bit 0 = D1 |
| in_rword | input | 23 | Received word to check, layout as in R1 |
| out_valid | output | 1 | Outputs carry a fresh result |
| out_code | output | 23 | Encoded codeword |
| out_syn | output | 7 | Syndrome of the received word, bit 0 = S1 |
| out_err | output | 1 | Syndrome is nonzero |

## Verification
The hardest case to reach from the ports is a received word that came out of the block's own encoder. Checking it needs the encoder output to be looped back into the syndrome path. The bench does this with a pipelined loop: each cycle it feeds the previous cycle's `out_code` into `in_rword` while it steps `in_data` through all 65536 values. Single-bit flips of a known codeword, and random error masks of one to three bits, probe the nonzero syndromes against columns the bench derives from the equations.

// File: rtl/cw_pkg.sv
// Package: shared widths, types and the check-bit selection masks of the
// (23,16) systematic code. Assumes bit 0 of a data word is D1 and bit 0 of
// the check field is C1; every module indexes the same way.
package cw_pkg;

    localparam int DATA_W = 16;
    localparam int CHK_W  = 7;
    localparam int CODE_W = DATA_W + CHK_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [CODE_W-1:0] code_t;

    // Returns which data bits feed check bit idx (idx 0 = C1).
    function automatic data_t chk_mask(input int idx);
        data_t m;
        case (idx)
            0:       m = 16'h23A9;
            1:       m = 16'h44DA;
            2:       m = 16'h9644;
            3:       m = 16'h1A89;
            4:       m = 16'h30F2;
            5:       m = 16'h9462;
            6:       m = 16'hDD24;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cw_parity_net.sv
// Parity network: forms the seven check bits of a 16-bit data field.
// Purely combinational; assumes the bit ordering of cw_pkg.
module cw_parity_net
    import cw_pkg::*;
(
    input  data_t data_i,
    output chk_t  chk_o
);

    // One XOR tree per check bit, selected by the package masks.
    for (genvar gi = 0; gi < CHK_W; gi++) begin : g_chk
        assign chk_o[gi] = ^(data_i & chk_mask(gi));
    end

endmodule

// File: rtl/cw_encoder.sv
// Encoder: places the data above its seven check bits to form a
// systematic codeword. Combinational; checks occupy bits [CHK_W-1:0].
module cw_encoder
    import cw_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);

    chk_t chk;

    cw_parity_net u_net (
        .data_i (data_i),
        .chk_o  (chk)
    );

    // Pack data over checks.
    assign code_o = {data_i, chk};

endmodule

// File: rtl/cw_syndrome.sv
// Syndrome generator: recomputes the checks over the received data field
// and compares them with the received checks. Combinational; assumes the
// received word uses the encoder layout.
module cw_syndrome
    import cw_pkg::*;
(
    input  code_t rword_i,
    output chk_t  syn_o,
    output logic  err_o
);

    chk_t  recomputed;
    data_t rx_data;
    chk_t  rx_chk;

    assign rx_data = rword_i[CODE_W-1:CHK_W];
    assign rx_chk  = rword_i[CHK_W-1:0];

    cw_parity_net u_net (
        .data_i (rx_data),
        .chk_o  (recomputed)
    );

    // Difference between received and recomputed checks.
    assign syn_o = recomputed ^ rx_chk;
    // Flag any mismatch.
    assign err_o = |syn_o;

endmodule

// File: rtl/cw_stage.sv
// Optional pipeline stage with a valid bit. EN=1 gives a register that
// loads only on valid and clears on synchronous active-low reset; EN=0
// passes through. Assumes rst_n is synchronous to clk.
module cw_stage #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] d_i,
    output logic         vld_o,
    output logic [W-1:0] q_o
);

    if (EN) begin : g_reg
        logic [W-1:0] q_r;
        logic         vld_r;

        // Capture data on valid, hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_r <= '0;
            end else if (vld_i) begin
                q_r <= d_i;
            end
        end

        // Delay the valid bit by one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_r <= 1'b0;
            end else begin
                vld_r <= vld_i;
            end
        end

        assign q_o   = q_r;
        assign vld_o = vld_r;

        // R8: an idle cycle leaves the stored value alone.
        p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && !vld_i) |=> $stable(q_o))
            else $error("p_hold_idle_r8");
    end else begin : g_bypass
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst_n;
        assign q_o   = d_i;
        assign vld_o = vld_i;
    end

endmodule

// File: rtl/cw23_codec.sv
// Top: (23,16) systematic encoder and syndrome generator sharing one
// valid strobe. IN_REG / OUT_REG add register stages at either side;
// latency is IN_REG + OUT_REG cycles. Error location is not done here.
module cw23_codec
    import cw_pkg::*;
#(
    parameter bit IN_REG  = 1'b0,
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] in_data,
    input  logic [22:0] in_rword,
    output logic        out_valid,
    output logic [22:0] out_code,
    output logic [6:0]  out_syn,
    output logic        out_err
);

    localparam int IN_W  = DATA_W + CODE_W;
    localparam int OUT_W = CODE_W + CHK_W + 1;
    localparam int LAT   = int'(IN_REG) + int'(OUT_REG);

    logic             s_vld;
    logic [IN_W-1:0]  s_bus;
    data_t            s_data;
    code_t            s_rword;
    code_t            enc_code;
    chk_t             syn;
    logic             err;
    logic [OUT_W-1:0] o_bus;

    cw_stage #(.W(IN_W), .EN(IN_REG)) u_in_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (in_valid),
        .d_i   ({in_data, in_rword}),
        .vld_o (s_vld),
        .q_o   (s_bus)
    );

    assign s_data  = s_bus[IN_W-1:CODE_W];
    assign s_rword = s_bus[CODE_W-1:0];

    cw_encoder u_enc (
        .data_i (s_data),
        .code_o (enc_code)
    );

    cw_syndrome u_syn (
        .rword_i (s_rword),
        .syn_o   (syn),
        .err_o   (err)
    );

    cw_stage #(.W(OUT_W), .EN(OUT_REG)) u_out_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (s_vld),
        .d_i   ({enc_code, syn, err}),
        .vld_o (out_valid),
        .q_o   (o_bus)
    );

    assign out_code = o_bus[OUT_W-1:CHK_W+1];
    assign out_syn  = o_bus[CHK_W:1];
    assign out_err  = o_bus[0];

    // R4: flag and syndrome travel together to the ports.
    p_err_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_err == (out_syn != '0))
        else $error("p_err_flag_r4");

    if (LAT == 1) begin : g_lat1_chk
        // R6: valid emerges exactly one cycle later.
        p_valid_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_valid == $past(in_valid)))
            else $error("p_valid_delay_r6");

        // R1: data field of the codeword is the sampled data word.
        p_data_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid)) |-> (out_code[CODE_W-1:CHK_W] == $past(in_data)))
            else $error("p_data_field_r1");

        // R7: a reset edge clears every output.
        p_reset_clear_r7: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && out_code == '0 && out_syn == '0 && !out_err))
            else $error("p_reset_clear_r7");
    end

endmodule

// File: tb/cw23_codec_bench.sv
`timescale 1ns/1ps
module cw23_codec_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_data;
    logic [22:0] in_rword;
    logic        out_valid;
    logic [22:0] out_code;
    logic [6:0]  out_syn;
    logic        out_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cw23_codec u_cw23_codec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_rword  (in_rword),
        .out_valid (out_valid),
        .out_code  (out_code),
        .out_syn   (out_syn),
        .out_err   (out_err)
    );

    // Expected checks written out from the R2 equations.
    function automatic logic [6:0] b_check(input logic [15:0] d);
        logic [6:0] c;
        c[0] = d[0]^d[3]^d[5]^d[7]^d[8]^d[9]^d[13];
        c[1] = d[1]^d[3]^d[4]^d[6]^d[7]^d[10]^d[14];
        c[2] = d[2]^d[6]^d[9]^d[10]^d[12]^d[15];
        c[3] = d[0]^d[3]^d[7]^d[9]^d[11]^d[12];
        c[4] = d[1]^d[4]^d[5]^d[6]^d[7]^d[12]^d[13];
        c[5] = d[1]^d[5]^d[6]^d[10]^d[12]^d[15];
        c[6] = d[2]^d[5]^d[8]^d[10]^d[11]^d[12]^d[14]^d[15];
        return c;
    endfunction

    function automatic logic [22:0] b_enc(input logic [15:0] d);
        return {d, b_check(d)};
    endfunction

    function automatic logic [6:0] b_syn(input logic [22:0] r);
        return b_check(r[22:7]) ^ r[6:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one valid transfer at a negedge; sample at the following negedge.
    task automatic xfer(input logic [15:0] d, input logic [22:0] r);
        in_valid = 1'b1;
        in_data  = d;
        in_rword = r;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [22:0] cw;
        logic [22:0] held_code;
        logic [6:0]  held_syn;
        void'($urandom(32'd2024));
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_data  = 16'hFFFF;
        in_rword = '1;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 valid", {31'd0, out_valid}, 32'd0);
        chk("R7 code",  {9'd0, out_code}, 32'd0);
        chk("R7 syn",   {25'd0, out_syn}, 32'd0);
        chk("R7 err",   {31'd0, out_err}, 32'd0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R6 idle valid", {31'd0, out_valid}, 32'd0);

        // R5 / R1 / R6: worked example.
        cw = b_enc(16'hF33B);
        xfer(16'hF33B, cw);
        chk("R5 checks", {25'd0, out_code[6:0]}, 32'h54);
        chk("R1 layout", {9'd0, out_code}, {9'd0, 16'hF33B, 7'h54});
        chk("R6 valid",  {31'd0, out_valid}, 32'd1);
        chk("R10 example syn", {25'd0, out_syn}, 32'd0);
        chk("R4 example err",  {31'd0, out_err}, 32'd0);

        // R8: idle edge with changed inputs.
        held_code = out_code;
        held_syn  = out_syn;
        in_valid  = 1'b0;
        in_data   = 16'h0000;
        in_rword  = 23'h7FFFFF;
        @(negedge clk);
        chk("R8 code hold", {9'd0, out_code}, {9'd0, held_code});
        chk("R8 syn hold",  {25'd0, out_syn}, {25'd0, held_syn});
        chk("R6 valid drop", {31'd0, out_valid}, 32'd0);

        // R9: every single-bit flip of the example codeword.
        for (int b = 0; b < 23; b++) begin
            logic [6:0] col;
            col = (b < 7) ? (7'd1 << b) : b_check(16'd1 << (b - 7));
            xfer(16'hF33B, cw ^ (23'd1 << b));
            chk("R9 flip syn", {25'd0, out_syn}, {25'd0, col});
            chk("R4 flip err", {31'd0, out_err}, 32'd1);
        end

        // R3 / R4: corner words.
        xfer(16'h0000, 23'h000000);
        chk("R3 zero syn", {25'd0, out_syn}, 32'd0);
        chk("R2 zero code", {9'd0, out_code}, 32'd0);
        xfer(16'hFFFF, 23'h7FFFFF);
        chk("R3 ones syn", {25'd0, out_syn}, {25'd0, b_syn(23'h7FFFFF)});
        chk("R2 ones code", {9'd0, out_code}, {9'd0, b_enc(16'hFFFF)});

        // R2 / R3 / R4: random data with 0..3 random error bits.
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] d;
            logic [22:0] e;
            logic [22:0] r;
            int nerr;
            d = 16'($urandom);
            nerr = $urandom_range(3, 0);
            e = '0;
            for (int j = 0; j < nerr; j++) e[$urandom_range(22, 0)] = 1'b1;
            r = b_enc(16'($urandom)) ^ e;
            xfer(d, r);
            chk("R2 random code", {9'd0, out_code}, {9'd0, b_enc(d)});
            chk("R3 random syn", {25'd0, out_syn}, {25'd0, b_syn(r)});
            chk("R4 random err", {31'd0, out_err}, {31'd0, (b_syn(r) != 7'd0)});
        end

        // R10: exhaustive loop-back of the block's own codewords.
        in_valid = 1'b1;
        in_data  = 16'd0;
        in_rword = '0;
        for (int k = 1; k <= 65536; k++) begin
            @(negedge clk);
            chk("R2 sweep code", {9'd0, out_code}, {9'd0, b_enc(16'(k - 1))});
            if (k >= 2) begin
                chk("R10 loopback syn", {25'd0, out_syn}, 32'd0);
                chk("R10 loopback err", {31'd0, out_err}, 32'd0);
            end
            in_rword = out_code;
            in_data  = 16'(k);
        end

        // R7: reset in mid-run clears non-zero outputs.
        xfer(16'hA5A5, 23'h7FFFFF);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 mid valid", {31'd0, out_valid}, 32'd0);
        chk("R7 mid code",  {9'd0, out_code}, 32'd0);
        chk("R7 mid syn",   {25'd0, out_syn}, 32'd0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule